// File: doc/BRIEF.md
# Write-Only Two-Wire Bus Slave Receiver

This block is the bus front end of a peripheral that only ever takes commands. It watches the serial clock and data lines with a fast system clock and cleans both lines. It then finds the bus conditions that open and close a transfer. It shifts each byte in most significant bit first and checks the first byte of every transfer against its own address. A single strap input supplies the one address bit that tells two sibling devices apart. The block never puts data on the bus. Its only drive on the data line is the acknowledge pull-down.

Once its address is accepted, the block acknowledges every byte that follows. Each such byte goes to a downstream command decoder as an 8-bit value with a one-cycle strobe. A one-cycle pulse also marks each START and each STOP, so the decoder can frame transfers. Two kinds of transfer are left alone for their whole length: transfers sent to another address, and read requests. For these the block releases the data line and stays quiet until the next START or STOP.

The control state machine has six states:
- `RX_IDLE`: the bus is free.
- `RX_ADDR`: collecting the address byte.
- `RX_ADDR_ACK`: acknowledging the address.
- `RX_DATA`: collecting a data byte.
- `RX_DATA_ACK`: acknowledging a data byte.
- `RX_SKIP`: the transfer is not for this device.

Its transitions are:
- Any START goes to `RX_ADDR`.
- Any STOP goes to `RX_IDLE`.
- `RX_ADDR` goes to `RX_ADDR_ACK` on a match, or to `RX_SKIP` otherwise. Both moves happen on the SCL fall after the eighth bit.
- `RX_ADDR_ACK` goes to `RX_DATA`, and `RX_DATA_ACK` goes to `RX_DATA`. Each move happens on the SCL fall that ends the ninth clock.
- `RX_DATA` goes to `RX_DATA_ACK` on the SCL fall after the eighth bit.

Top module: `i2c_wo_slave`

## Requirements
- R1: A falling SDA while SCL is high produces one `start_pulse`. A rising SDA while SCL is high produces one `stop_pulse`. Each pulse lasts one clock cycle and comes once per condition, whether or not the device is addressed.
- R2: Bits are taken on SCL rising edges, most significant bit first. SDA changes while SCL is low are never taken as conditions.
- R3: The address byte is accepted and acknowledged when all of the following hold:
  - bits 7..2 equal 011100;
  - bit 1 equals `sel_strap`;
  - bit 0 (1 = read, 0 = write) is 0.
- R4: An address byte with bit 0 set (a read) is not acknowledged. The rest of that transfer is ignored.
- R5: After an address mismatch, no byte of that transfer is acknowledged or reported. `sda_oe` stays 0 until a STOP or a new START.
- R6: In a selected transfer, every data byte is acknowledged. `sda_oe` stays 1 through the whole SCL high phase of the ninth clock.
- R7: No limit applies to the number of data bytes between START and STOP.
- R8: `sda_oe` is set only after the SCL fall that follows the eighth bit, while SCL is low. It is cleared after the SCL fall that ends the ninth clock. It is 0 at all other times.
- R9: Each acknowledged data byte gives a one-cycle `rx_valid` with the received byte on `rx_data`. An address byte never raises `rx_valid`.
- R10: A repeated START clears any partly received byte and returns the block to address reception.
- R11: After reset, `sda_oe`, `rx_valid`, `start_pulse` and `stop_pulse` are all 0.
- R12: A pulse on SDA or SCL that lasts a single system clock cycle is filtered out and produces no condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sel_strap | input | 1 | Strap level compared with address bit 1 |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge); 0 releases it |
| rx_data | output | 8 | Last acknowledged data byte |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_data` |
| start_pulse | output | 1 | One-cycle marker for a START or repeated START |
| stop_pulse | output | 1 | One-cycle marker for a STOP |

## Verification
The hardest case to reach is a repeated START that lands in the middle of a byte. It has to arrive when the bit counter holds a nonzero count. The counter must then be cleared, so that the next address is read correctly. The bench sends an address and a few data bits, drives SDA high while SCL is low, and then makes a new START. It then checks that the following address is acknowledged and that the next data byte arrives unshifted. A second hard case is a mismatched transfer whose data byte looks exactly like a valid address. It shows that the block stays in its skip state until a START.

// File: rtl/i2c_wo_pkg.sv
package i2c_wo_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        RX_IDLE     = 3'd0,
        RX_ADDR     = 3'd1,
        RX_ADDR_ACK = 3'd2,
        RX_DATA     = 3'd3,
        RX_DATA_ACK = 3'd4,
        RX_SKIP     = 3'd5
    } rx_state_e;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int VOTE_TAPS   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [VOTE_TAPS-1:0]   taps_q;

    function automatic logic vote(input logic [VOTE_TAPS-1:0] t);
        int ones;
        ones = 0;
        for (int i = 0; i < VOTE_TAPS; i++) begin
            ones = ones + int'(t[i]);
        end
        return ones > (VOTE_TAPS / 2);
    endfunction

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= line_i;
            end
        end else begin : g_syncn
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            end
        end
    endgenerate

    generate
        if (VOTE_TAPS == 1) begin : g_tap1
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) taps_q <= '1;
                else        taps_q <= sync_q[SYNC_STAGES-1];
            end
        end else begin : g_tapn
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) taps_q <= '1;
                else        taps_q <= {taps_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_o <= 1'b1;
        else        line_o <= vote(taps_q);
    end

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        scl_rise  = scl_f & ~scl_q;
        scl_fall  = ~scl_f & scl_q;
        start_det = scl_f & scl_q & sda_q & ~sda_f;
        stop_det  = scl_f & scl_q & ~sda_q & sda_f;
    end

endmodule

// File: rtl/i2c_rx_ctrl.sv
module i2c_rx_ctrl
    import i2c_wo_pkg::*;
#(
    parameter logic [5:0] ADDR_HI = 6'b011100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_f,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sel_strap,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              start_pulse,
    output logic              stop_pulse,
    output rx_state_e         state
);

    localparam int CNT_W = $clog2(BYTE_W + 1);

    rx_state_e         nxt;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              byte_full;
    logic              addr_hit;
    logic              collecting;

    always_comb begin
        byte_full  = (bit_cnt == CNT_W'(BYTE_W));
        addr_hit   = (shreg[7:2] == ADDR_HI) && (shreg[1] == sel_strap) && !shreg[0];
        collecting = (state == RX_ADDR) || (state == RX_DATA);
    end

    // next-state selection
    always_comb begin
        nxt = state;
        if (start_det) begin
            nxt = RX_ADDR;
        end else if (stop_det) begin
            nxt = RX_IDLE;
        end else begin
            unique case (state)
                RX_IDLE:     nxt = RX_IDLE;
                RX_SKIP:     nxt = RX_SKIP;
                RX_ADDR:     if (scl_fall && byte_full) nxt = addr_hit ? RX_ADDR_ACK : RX_SKIP;
                RX_ADDR_ACK: if (scl_fall) nxt = RX_DATA;
                RX_DATA:     if (scl_fall && byte_full) nxt = RX_DATA_ACK;
                RX_DATA_ACK: if (scl_fall) nxt = RX_DATA;
                default:     nxt = RX_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt     <= '0;
            shreg       <= '0;
            rx_data     <= '0;
            rx_valid    <= 1'b0;
            start_pulse <= 1'b0;
            stop_pulse  <= 1'b0;
            sda_oe      <= 1'b0;
        end else begin
            rx_valid    <= 1'b0;
            start_pulse <= 1'b0;
            stop_pulse  <= 1'b0;
            sda_oe      <= (nxt == RX_ADDR_ACK) || (nxt == RX_DATA_ACK);
            if (start_det) begin
                bit_cnt     <= '0;
                start_pulse <= 1'b1;
            end else if (stop_det) begin
                bit_cnt    <= '0;
                stop_pulse <= 1'b1;
            end else if (collecting) begin
                if (scl_rise && !byte_full) begin
                    shreg   <= {shreg[BYTE_W-2:0], sda_f};
                    bit_cnt <= bit_cnt + CNT_W'(1);
                end
                if (scl_fall && byte_full) begin
                    bit_cnt <= '0;
                    if (state == RX_DATA) begin
                        rx_data  <= shreg;
                        rx_valid <= 1'b1;
                    end
                end
            end else if (state != RX_ADDR_ACK && state != RX_DATA_ACK) begin
                bit_cnt <= '0;
            end
        end
    end

endmodule

// File: rtl/i2c_wo_slave.sv
module i2c_wo_slave
    import i2c_wo_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         VOTE_TAPS   = 3,
    parameter logic [5:0] ADDR_HI     = 6'b011100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              sel_strap,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              start_pulse,
    output logic              stop_pulse
);

    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] filt_lines;
    logic               scl_filt;
    logic               sda_filt;
    logic               scl_rise;
    logic               scl_fall;
    logic               start_det;
    logic               stop_det;
    rx_state_e          rx_state;

    assign raw_lines = {sda_i, scl_i};
    assign scl_filt  = filt_lines[0];
    assign sda_filt  = filt_lines[1];

    generate
        for (genvar g = 0; g < N_LINES; g++) begin : g_line
            i2c_line_filter #(
                .SYNC_STAGES(SYNC_STAGES),
                .VOTE_TAPS  (VOTE_TAPS)
            ) u_filt (
                .clk   (clk),
                .rst_n (rst_n),
                .line_i(raw_lines[g]),
                .line_o(filt_lines[g])
            );
        end
    endgenerate

    i2c_bus_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (scl_filt),
        .sda_f    (sda_filt),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2c_rx_ctrl #(
        .ADDR_HI(ADDR_HI)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_f      (sda_filt),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .sel_strap  (sel_strap),
        .sda_oe     (sda_oe),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .start_pulse(start_pulse),
        .stop_pulse (stop_pulse),
        .state      (rx_state)
    );

endmodule

// File: rtl/i2c_wo_slave_chk.sv
module i2c_wo_slave_chk
    import i2c_wo_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      sda_oe,
    input logic      rx_valid,
    input logic      start_pulse,
    input logic      stop_pulse,
    input logic      scl_f,
    input rx_state_e state
);

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R9

    AST_VALID_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (sda_oe && state == RX_DATA_ACK)); // R9

    AST_OE_SET_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_f); // R8

    AST_OE_DROP_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_f); // R8

    AST_OE_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe && scl_f) |=> sda_oe); // R6

    AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> (state == RX_ADDR && !sda_oe)); // R10

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |-> (state == RX_IDLE && !sda_oe)); // R1

    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_SKIP) |-> (!sda_oe && !rx_valid)); // R5

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_pulse && stop_pulse)); // R1

endmodule

bind i2c_wo_slave i2c_wo_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_oe     (sda_oe),
    .rx_valid   (rx_valid),
    .start_pulse(start_pulse),
    .stop_pulse (stop_pulse),
    .scl_f      (scl_filt),
    .state      (rx_state)
);

// File: tb/i2c_wo_slave_tb.sv
`timescale 1ns/1ps
module i2c_wo_slave_tb;

    localparam int Q = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sel_strap = 1'b0;
    logic       sda_oe;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       start_pulse;
    logic       stop_pulse;
    logic       sda_bus;

    int n_tests = 0;
    int n_fail  = 0;
    int n_start = 0;
    int n_stop  = 0;
    int n_valid = 0;
    logic [7:0] cap [0:63];
    bit   oe_seen = 1'b0;

    assign sda_bus = m_sda & ~sda_oe;

    always #2 clk = ~clk;

    i2c_wo_slave u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_bus),
        .sel_strap  (sel_strap),
        .sda_oe     (sda_oe),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .start_pulse(start_pulse),
        .stop_pulse (stop_pulse)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (start_pulse) n_start++;
            if (stop_pulse)  n_stop++;
            if (sda_oe)      oe_seen = 1'b1;
            if (rx_valid) begin
                cap[n_valid % 64] = rx_data;
                n_valid++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic bus_bit(input logic b);
        m_sda = b; wq();
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0; wq();
    endtask

    // ack[1] = low early in the high phase, ack[0] = low late; rel = released after the clock
    task automatic send_byte(input logic [7:0] b, output logic [1:0] ack, output logic rel);
        for (int i = 7; i >= 0; i--) bus_bit(b[i]);
        m_sda = 1'b1; wq();
        m_scl = 1'b1;
        repeat (2) @(negedge clk);
        ack[1] = ~sda_bus;
        repeat (2 * Q - 4) @(negedge clk);
        ack[0] = ~sda_bus;
        repeat (2) @(negedge clk);
        m_scl = 1'b0; wq();
        rel = ~sda_oe;
    endtask

    // {strap, address byte, data byte, expect acknowledge}
    localparam logic [17:0] VEC [8] = '{
        {1'b0, 8'h70, 8'hA5, 1'b1},
        {1'b1, 8'h72, 8'h3C, 1'b1},
        {1'b0, 8'h72, 8'h11, 1'b0},
        {1'b1, 8'h70, 8'h22, 1'b0},
        {1'b0, 8'h71, 8'h33, 1'b0},
        {1'b1, 8'h73, 8'h44, 1'b0},
        {1'b0, 8'h60, 8'h55, 1'b0},
        {1'b0, 8'hF0, 8'h66, 1'b0}
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [1:0] ack;
        logic       rel;
        int s0, p0, v0;

        repeat (5) @(negedge clk);
        chk(sda_oe == 0 && rx_valid == 0 && start_pulse == 0 && stop_pulse == 0,
            "R11 reset outputs", {sda_oe, rx_valid, start_pulse, stop_pulse}, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(sda_oe == 0 && n_start == 0, "R11 idle after reset", n_start, 0);

        // R12: single-cycle SDA glitch while the bus is idle
        s0 = n_start;
        m_sda = 1'b0; @(negedge clk); m_sda = 1'b1;
        wq();
        chk(n_start == s0, "R12 sda glitch no start", n_start - s0, 0);

        // table of single-byte transfers (R1 R3 R4 R5 R6 R9)
        for (int k = 0; k < 8; k++) begin
            logic [1:0] a_ack, d_ack;
            logic       a_rel, d_rel;
            sel_strap = VEC[k][17];
            wq();
            s0 = n_start; p0 = n_stop; v0 = n_valid; oe_seen = 1'b0;
            bus_start();
            send_byte(VEC[k][16:9], a_ack, a_rel);
            send_byte(VEC[k][8:1], d_ack, d_rel);
            bus_stop();
            wq();
            chk(a_ack == {2{VEC[k][0]}}, "R3/R4 address ack", a_ack, {2{VEC[k][0]}});
            chk(d_ack == {2{VEC[k][0]}}, "R6/R5 data ack", d_ack, {2{VEC[k][0]}});
            chk(a_rel && d_rel, "R8 released after ninth clock", {a_rel, d_rel}, 3);
            chk(n_valid - v0 == int'(VEC[k][0]), "R9 valid count", n_valid - v0, VEC[k][0]);
            if (VEC[k][0])
                chk(cap[v0 % 64] == VEC[k][8:1], "R2 data MSB first", cap[v0 % 64], VEC[k][8:1]);
            else
                chk(!oe_seen, "R5 sda never driven", oe_seen, 0);
            chk(n_start - s0 == 1 && n_stop - p0 == 1, "R1 start/stop pulses",
                {n_start - s0, n_stop - p0}, 'h11);
        end

        // R7: long burst
        sel_strap = 1'b0;
        wq();
        v0 = n_valid;
        bus_start();
        send_byte(8'h70, ack, rel);
        begin
            int bad;
            bad = 0;
            for (int i = 0; i < 20; i++) begin
                send_byte(8'(i * 13 + 7), ack, rel);
                if (ack != 2'b11 || !rel) bad++;
            end
            bus_stop();
            wq();
            chk(bad == 0, "R7 every burst byte acked", bad, 0);
            chk(n_valid - v0 == 20, "R7 burst count", n_valid - v0, 20);
            bad = 0;
            for (int i = 0; i < 20; i++)
                if (cap[(v0 + i) % 64] != 8'(i * 13 + 7)) bad++;
            chk(bad == 0, "R7 burst data", bad, 0);
        end

        // R10: repeated START in the middle of a data byte
        v0 = n_valid; s0 = n_start;
        bus_start();
        send_byte(8'h70, ack, rel);
        bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1);
        bus_start();
        send_byte(8'h70, ack, rel);
        chk(ack == 2'b11, "R10 address after repeated start", ack, 3);
        send_byte(8'h5A, ack, rel);
        bus_stop();
        wq();
        chk(n_start - s0 == 2, "R10 two starts", n_start - s0, 2);
        chk(n_valid - v0 == 1 && cap[v0 % 64] == 8'h5A, "R10 clean byte after restart",
            cap[v0 % 64], 8'h5A);

        // R5: mismatch, then a data byte equal to a valid address, then a restart
        v0 = n_valid; oe_seen = 1'b0;
        bus_start();
        send_byte(8'h72, ack, rel);
        send_byte(8'h70, ack, rel);
        chk(ack == 2'b00 && !oe_seen, "R5 look-alike byte ignored", ack, 0);
        bus_start();
        send_byte(8'h70, ack, rel);
        chk(ack == 2'b11, "R5 new start re-arms", ack, 3);
        send_byte(8'hC3, ack, rel);
        bus_stop();
        wq();
        chk(n_valid - v0 == 1 && cap[v0 % 64] == 8'hC3, "R9 byte after re-arm",
            cap[v0 % 64], 8'hC3);

        // R12: single-cycle SCL glitch in a low phase adds no bit
        v0 = n_valid;
        bus_start();
        send_byte(8'h70, ack, rel);
        m_sda = 1'b1; wq();
        m_scl = 1'b1; @(negedge clk); m_scl = 1'b0; wq();
        send_byte(8'h96, ack, rel);
        bus_stop();
        wq();
        chk(n_valid - v0 == 1 && cap[v0 % 64] == 8'h96, "R12 scl glitch ignored",
            cap[v0 % 64], 8'h96);
        chk(sda_oe == 0, "R8 idle release", sda_oe, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule